// File: doc/BRIEF.md
# UART Receiver Wake-Up and Status Control

This block sits behind a UART receive shifter and decides which receive events become visible to software. The shifter reports each completed frame together with its data and its noise and framing-error verdicts. An idle detector pulses when the line has gone quiet. The bit sampler also hands over every sampled line bit. From these inputs the block keeps the received-data register and five sticky status flags: data ready, idle, overrun, noise and framing error.

Two control bits gate the flags: a receive enable and a sleep (wake-up) bit. While the receiver is disabled or asleep, no flag can be set. Flags that are already set stay set. Sleep ends on its own, and the wake method picks how. In idle-line wake mode, sleep ends on a frame-length run of one bits. In address-mark wake mode, sleep ends on a frame whose most significant data bit is set. Software clears the flags by reading status and then reading data.

Top module: `uart_rx_wake`

## Requirements
- R1: Reset forces receive enable, the sleep bit, all five flags and the data register to 0. Each control write takes effect on the next clock edge.
- R2: While receive enable is 0, no flag is set. Frame and idle events are ignored, and the data register is not loaded.
- R3: While the sleep bit is 1, no flag is set and no frame is stored. Flags that were set before sleep stay set.
- R4: In idle-line wake mode (`wake_addr`=0), the sleep bit clears on the edge that takes the 10th consecutive one sample in 8-bit format (`nine_bit`=0), or the 11th in 9-bit format. A zero sample restarts the count. The count is held at zero while the receiver is disabled.
- R5: In idle-line wake mode, a write of 1 to the sleep bit is ignored while the line is idle, meaning the current run of ones has reached frame length. A write of 0 always takes effect.
- R6: In address-mark wake mode, a frame with its address bit set clears the sleep bit and is received as a normal frame: it is stored and sets data ready. The address bit is data bit 7 in 8-bit format and bit 8 in 9-bit format. A wake event overrides a sleep write made in the same cycle.
- R7: A frame accepted while data ready is set, and not being cleared in that cycle, sets overrun. Its data is discarded, and its noise and framing verdicts are dropped.
- R8: An accepted frame with room loads the data register and sets data ready. It sets noise and framing error from its verdicts. In 8-bit format, stored bit 8 is 0. A data read that follows a status read clears all five flags. A data read without a prior status read clears nothing.
- R9: An idle pulse sets the idle flag when the receiver is enabled and awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nine_bit | input | 1 | Frame format: 0 = 8 data bits, 1 = 9 data bits |
| wake_addr | input | 1 | Wake method: 0 = idle-line, 1 = address-mark |
| en_wr | input | 1 | Write strobe for receive enable |
| en_wdata | input | 1 | Value written to receive enable |
| sleep_wr | input | 1 | Write strobe for the sleep bit |
| sleep_wdata | input | 1 | Value written to the sleep bit |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| frame_done | input | 1 | A frame completed this cycle |
| frame_data | input | 9 | Data of the completed frame |
| frame_noise | input | 1 | Noise verdict of the completed frame |
| frame_ferr | input | 1 | Framing-error verdict of the completed frame |
| line_idle | input | 1 | Idle-line detector pulse |
| bit_tick | input | 1 | A line bit was sampled this cycle |
| bit_val | input | 1 | Value of the sampled bit |
| rx_en | output | 1 | Receive enable |
| sleep | output | 1 | Sleep (wake-up) bit |
| rdy | output | 1 | Data ready flag |
| idle_f | output | 1 | Idle flag |
| ovr | output | 1 | Overrun flag |
| noise_f | output | 1 | Noise flag |
| ferr_f | output | 1 | Framing-error flag |
| rx_data | output | 9 | Received data register |

## Verification
The idle-line wake is tried with runs of ones one short of frame length, exactly at frame length, and broken by a zero, in both formats. This separates a correct run length from off-by-one counting and shows whether the format changes the count. Address-mark wake is tried with frames whose bit 7 and bit 8 are set separately. This shows which bit the format selects as the address. Random mixes of frames, reads, idle pulses and control writes are checked against a bench model. These runs cover the order of overrun, clear and store when several events share a cycle.

// File: rtl/uart_rx_wake.sv
`timescale 1ns/1ps
module uart_rx_wake #(
  parameter int DW = 9,
  parameter int RUN8 = 10,
  parameter int RUN9 = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nine_bit,
  input  logic          wake_addr,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          sleep_wr,
  input  logic          sleep_wdata,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_noise,
  input  logic          frame_ferr,
  input  logic          line_idle,
  input  logic          bit_tick,
  input  logic          bit_val,
  output logic          rx_en,
  output logic          sleep,
  output logic          rdy,
  output logic          idle_f,
  output logic          ovr,
  output logic          noise_f,
  output logic          ferr_f,
  output logic [DW-1:0] rx_data
);
  localparam int CW = $clog2(RUN9 + 1);

  logic [CW-1:0] ones_q, ones_d;
  logic          armed;

  wire [CW-1:0] run_len  = nine_bit ? CW'(RUN9) : CW'(RUN8);
  wire          idle_now = ones_q >= run_len;
  wire          addr_bit = nine_bit ? frame_data[DW-1] : frame_data[DW-2];
  wire          clr      = data_rd && armed;
  wire          awake    = rx_en && !sleep;
  wire          take     = frame_done && rx_en && (!sleep || (wake_addr && addr_bit));
  wire          room     = !rdy || clr;
  wire          store    = take && room;
  wire          lost     = take && !room;
  wire          wake_ev  = rx_en && (wake_addr ? (frame_done && addr_bit) : (ones_d >= run_len));
  wire          wr_ok    = sleep_wr && !(sleep_wdata && !wake_addr && idle_now);
  wire [DW-1:0] kept     = nine_bit ? frame_data : {1'b0, frame_data[DW-2:0]};

  always_comb begin
    ones_d = ones_q;
    if (!rx_en)
      ones_d = '0;
    else if (bit_tick)
      ones_d = !bit_val ? '0 : (idle_now ? ones_q : ones_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      sleep   <= 1'b0;
      armed   <= 1'b0;
      ones_q  <= '0;
      rdy     <= 1'b0;
      idle_f  <= 1'b0;
      ovr     <= 1'b0;
      noise_f <= 1'b0;
      ferr_f  <= 1'b0;
      rx_data <= '0;
    end else begin
      if (en_wr) rx_en <= en_wdata;
      if (wr_ok) sleep <= sleep_wdata;
      if (wake_ev) sleep <= 1'b0;
      if (data_rd) armed <= 1'b0;
      else if (stat_rd) armed <= 1'b1;
      ones_q  <= ones_d;
      rdy     <= (rdy && !clr) || store;
      ovr     <= (ovr && !clr) || lost;
      noise_f <= (noise_f && !clr) || (store && frame_noise);
      ferr_f  <= (ferr_f && !clr) || (store && frame_ferr);
      idle_f  <= (idle_f && !clr) || (line_idle && awake);
      if (store) rx_data <= kept;
    end
  end
endmodule

// File: rtl/uart_rx_wake_chk.sv
`timescale 1ns/1ps
module uart_rx_wake_chk #(
  parameter int DW = 9,
  parameter int RUN8 = 10,
  parameter int RUN9 = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nine_bit,
  input logic          wake_addr,
  input logic          sleep_wr,
  input logic          sleep_wdata,
  input logic          data_rd,
  input logic          frame_done,
  input logic [DW-1:0] frame_data,
  input logic          bit_tick,
  input logic          bit_val,
  input logic          rx_en,
  input logic          sleep,
  input logic          rdy,
  input logic          idle_f,
  input logic          ovr,
  input logic          noise_f,
  input logic          ferr_f,
  input logic [DW-1:0] rx_data
);
  logic [4:0] ck_run;
  logic       ck_hit, ck_ign, ck_aw;
  wire  [4:0] ck_len = nine_bit ? 5'(RUN9) : 5'(RUN8);
  wire  [4:0] flags  = {rdy, idle_f, ovr, noise_f, ferr_f};
  wire        ck_adr = nine_bit ? frame_data[DW-1] : frame_data[DW-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_run <= '0;
      ck_hit <= 1'b0;
      ck_ign <= 1'b0;
      ck_aw  <= 1'b0;
    end else begin
      if (!rx_en) ck_run <= '0;
      else if (bit_tick) ck_run <= bit_val ? ((ck_run == 5'd31) ? ck_run : ck_run + 5'd1) : 5'd0;
      ck_hit <= rx_en && !wake_addr && bit_tick && bit_val && (ck_run + 5'd1 >= ck_len);
      ck_ign <= sleep_wr && sleep_wdata && !wake_addr && !sleep && (ck_run >= ck_len);
      ck_aw  <= rx_en && wake_addr && frame_done && ck_adr;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!rx_en && !sleep && flags == 5'd0)); // R1
  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) !$past(rx_en) |-> (flags & ~$past(flags)) == 5'd0); // R2
  AST_ASLEEP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) ($past(sleep) && sleep) |-> (flags & ~$past(flags)) == 5'd0); // R3
  AST_RUN_WAKES: assert property (@(posedge clk) disable iff (!rst_n) ck_hit |-> !sleep); // R4
  AST_IDLE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) ck_ign |-> !sleep); // R5
  AST_ADDR_WAKES: assert property (@(posedge clk) disable iff (!rst_n) ck_aw |-> (!sleep && rdy)); // R6
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en && !sleep && frame_done && rdy && !data_rd) |-> (ovr && $stable(rx_data))); // R7
endmodule

bind uart_rx_wake uart_rx_wake_chk #(.DW(DW), .RUN8(RUN8), .RUN9(RUN9)) u_chk (
  .clk(clk), .rst_n(rst_n), .nine_bit(nine_bit), .wake_addr(wake_addr),
  .sleep_wr(sleep_wr), .sleep_wdata(sleep_wdata), .data_rd(data_rd),
  .frame_done(frame_done), .frame_data(frame_data), .bit_tick(bit_tick),
  .bit_val(bit_val), .rx_en(rx_en), .sleep(sleep), .rdy(rdy), .idle_f(idle_f),
  .ovr(ovr), .noise_f(noise_f), .ferr_f(ferr_f), .rx_data(rx_data)
);

// File: tb/uart_rx_wake_test.sv
`timescale 1ns/1ps
module uart_rx_wake_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nine_bit = 0, wake_addr = 0, en_wr = 0, en_wdata = 0, sleep_wr = 0, sleep_wdata = 0;
  logic stat_rd = 0, data_rd = 0, frame_done = 0, frame_noise = 0, frame_ferr = 0;
  logic line_idle = 0, bit_tick = 0, bit_val = 0;
  logic [8:0] frame_data = '0;
  logic rx_en, sleep, rdy, idle_f, ovr, noise_f, ferr_f;
  logic [8:0] rx_data;

  int n_chk = 0, n_bad = 0;
  bit m_en, m_sl, m_rdy, m_idle, m_ovr, m_noi, m_fe, m_arm;
  bit [8:0] m_data;
  int m_run;

  always #4 clk = ~clk;

  uart_rx_wake uut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    {m_en, m_sl, m_rdy, m_idle, m_ovr, m_noi, m_fe, m_arm} = '0;
    m_data = '0; m_run = 0;
  endtask

  function automatic int need_run(bit nb);
    return nb ? 11 : 10;
  endfunction

  task automatic model_step();
    bit idle_line, adr, wipe, accept, wake;
    int run_n;
    idle_line = m_run >= need_run(nine_bit);
    adr   = nine_bit ? frame_data[8] : frame_data[7];
    wipe  = data_rd && m_arm;
    accept = m_en && frame_done && (!m_sl || (wake_addr && adr));
    run_n = m_run;
    if (!m_en) run_n = 0;
    else if (bit_tick) run_n = bit_val ? (idle_line ? m_run : m_run + 1) : 0;
    wake = m_en && (wake_addr ? (frame_done && adr) : (run_n >= need_run(nine_bit)));
    if (wipe) {m_rdy, m_idle, m_ovr, m_noi, m_fe} = '0;
    if (m_en && !m_sl && line_idle) m_idle = 1;
    if (accept) begin
      if (m_rdy) m_ovr = 1;
      else begin
        m_rdy = 1; m_data = nine_bit ? frame_data : {1'b0, frame_data[7:0]};
        m_noi |= frame_noise; m_fe |= frame_ferr;
      end
    end
    if (sleep_wr && !(sleep_wdata && !wake_addr && idle_line)) m_sl = sleep_wdata;
    if (wake) m_sl = 0;
    if (en_wr) m_en = en_wdata;
    m_arm = data_rd ? 0 : (stat_rd ? 1 : m_arm);
    m_run = run_n;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #2;
    {en_wr, sleep_wr, stat_rd, data_rd, frame_done, frame_noise, frame_ferr, line_idle, bit_tick} = '0;
  endtask

  task automatic do_frame(logic [8:0] d, bit n, bit f);
    frame_done = 1; frame_data = d; frame_noise = n; frame_ferr = f; cyc();
  endtask
  task automatic do_bit(bit v);     bit_tick = 1; bit_val = v; cyc(); endtask
  task automatic do_en(bit v);      en_wr = 1; en_wdata = v; cyc(); endtask
  task automatic do_sleep(bit v);   sleep_wr = 1; sleep_wdata = v; cyc(); endtask
  task automatic do_clear();        stat_rd = 1; cyc(); data_rd = 1; cyc(); endtask

  task automatic cmp_all();
    chk("RALL en", rx_en, m_en);     chk("RALL sleep", sleep, m_sl);
    chk("RALL rdy", rdy, m_rdy);     chk("RALL idle", idle_f, m_idle);
    chk("RALL ovr", ovr, m_ovr);     chk("RALL noise", noise_f, m_noi);
    chk("RALL ferr", ferr_f, m_fe);  chk("RALL data", rx_data, m_data);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk("R1 en", rx_en, 0); chk("R1 sleep", sleep, 0);
    chk("R1 flags", {rdy, idle_f, ovr, noise_f, ferr_f}, 0); chk("R1 data", rx_data, 0);

    do_frame(9'h055, 1, 1); line_idle = 1; cyc();
    chk("R2 flags", {rdy, idle_f, ovr, noise_f, ferr_f}, 0); chk("R2 data", rx_data, 0);

    do_en(1); chk("R1 en write", rx_en, 1);
    do_frame(9'h1A5, 1, 0);
    chk("R8 rdy", rdy, 1); chk("R8 data 8-bit", rx_data, 9'h0A5); chk("R8 noise", noise_f, 1);
    do_frame(9'h033, 0, 1);
    chk("R7 ovr", ovr, 1); chk("R7 data kept", rx_data, 9'h0A5); chk("R7 ferr dropped", ferr_f, 0);
    data_rd = 1; cyc(); chk("R8 bare read", rdy, 1);
    do_clear(); chk("R8 cleared", {rdy, idle_f, ovr, noise_f, ferr_f}, 0);
    line_idle = 1; cyc(); chk("R9 idle", idle_f, 1);
    do_clear();

    do_frame(9'h011, 0, 0); do_sleep(1); chk("R3 sleep set", sleep, 1);
    do_frame(9'h022, 1, 0); line_idle = 1; cyc();
    chk("R3 rdy kept", rdy, 1); chk("R3 no ovr", ovr, 0); chk("R3 no noise", noise_f, 0);
    chk("R3 no idle", idle_f, 0); chk("R3 data", rx_data, 9'h011);
    do_clear();
    for (int i = 0; i < 9; i++) do_bit(1);
    chk("R4 9 ones", sleep, 1);
    do_bit(1); chk("R4 10 ones", sleep, 0);
    do_bit(0); nine_bit = 1; do_sleep(1);
    for (int i = 0; i < 5; i++) do_bit(1);
    do_bit(0);
    for (int i = 0; i < 10; i++) do_bit(1);
    chk("R4 10 ones 9-bit", sleep, 1);
    do_bit(1); chk("R4 11 ones 9-bit", sleep, 0);
    do_sleep(1); chk("R5 ignored", sleep, 0);
    do_bit(0); do_sleep(1); chk("R5 accepted", sleep, 1);

    wake_addr = 1; nine_bit = 0;
    do_frame(9'h07F, 0, 0); chk("R6 no wake", sleep, 1); chk("R6 no rdy", rdy, 0);
    do_frame(9'h080, 0, 0); chk("R6 wake 8", sleep, 0); chk("R6 rdy", rdy, 1); chk("R6 data", rx_data, 9'h080);
    do_clear(); nine_bit = 1; do_sleep(1);
    do_frame(9'h0FF, 0, 0); chk("R6 bit7 in 9-bit", sleep, 1);
    do_frame(9'h100, 0, 0); chk("R6 wake 9", sleep, 0); chk("R6 data 9", rx_data, 9'h100);
    do_sleep(1);
    rst_n = 0; #2; chk("R1 reset en", rx_en, 0); chk("R1 reset sleep", sleep, 0);
    model_reset(); @(posedge clk); #2 rst_n = 1;

    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(99) < 1) nine_bit = $urandom_range(1);
      if ($urandom_range(99) < 1) wake_addr = $urandom_range(1);
      en_wr = ($urandom_range(99) < 3); en_wdata = ($urandom_range(9) != 0);
      sleep_wr = ($urandom_range(99) < 6); sleep_wdata = $urandom_range(1);
      stat_rd = ($urandom_range(9) == 0); data_rd = ($urandom_range(9) == 0);
      frame_done = ($urandom_range(9) == 0); frame_data = 9'($urandom);
      frame_noise = ($urandom_range(3) == 0); frame_ferr = ($urandom_range(3) == 0);
      line_idle = ($urandom_range(29) == 0);
      bit_tick = $urandom_range(1); bit_val = ($urandom_range(9) != 0);
      cyc();
      cmp_all();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'h5EED_0042));
endmodule